// File: doc/BRIEF.md
# Two-Stage Unlockable Watchdog

The block is a watchdog that counts down in two phases. When the first phase runs out it emits a one-cycle interrupt pulse of a kind chosen by configuration. It then counts the second phase. When that phase runs out it asks for a reboot, sets a sticky "last reboot came from the watchdog" flag, and returns the rest of its state to reset values. The length of each phase is a 20-bit preload scaled by one of two shifts, counted in cycles of the block's clock.

Software controls the block through two small control registers, configuration and lock, and a 16-byte window that holds the preloads and a reload/status register. A write to the window only has an effect after a two-write magic sequence. That sequence is good for exactly one later halfword or word write. The lock bit freezes the lock register until the next device reset. The sticky flag survives device reset and clears only at power-on or through an unlocked write.

Top module: `dual_stage_wdog`

## Requirements
- R1: After power-on, all three pulse outputs are low, both control registers read 0, and a halfword read of the window at offset 0xC returns 0.
- R2: A phase lasts preload<<5 cycles when configuration bit 2 is 1 and preload<<15 cycles when it is 0. A word write of a preload keeps only the low 20 bits of the data.
- R3: At the end of phase one, configuration bits [1:0] = 0 give one cycle of `irqPulse`, 2 gives one cycle of `smiPulse`, and 1 or 3 give no pulse. Phase two then starts from the phase-two preload.
- R4: At the end of phase two, with configuration bit 5 = 0, `rebootPulse` is high for one cycle and the sticky flag is set. The configuration, the lock register and the preloads return to reset values.
- R5: At the end of phase two, with configuration bit 5 = 1, no reboot occurs. If lock bit 2 (free-run) is set, phase one restarts; otherwise counting stops.
- R6: A lock-register write that takes bit 1 (enable) from 0 to 1 starts phase one. A write with bit 1 = 0 stops counting.
- R7: Once lock bit 0 is set, writes to the lock register are ignored until a device reset or a watchdog reboot.
- R8: A write of 0x80 to offset 0xC and then a write of 0x86 to offset 0xC opens the window. Only the next halfword or word write is acted on, and that write closes the window again. Window writes made while it is closed have no effect.
- R9: With the window open and the watchdog enabled, a halfword write to offset 0xC with bit 8 set restarts phase one. With the watchdog disabled it starts nothing.
- R10: A halfword read at offset 0xC returns 0x1200 while the sticky flag is set. The flag stays set through device reset. An unlocked halfword write to 0xC with bit 9 or bit 12 set clears it.
- R11: A preload written while a phase is counting does not change that phase. It takes effect at the next load of its own phase.
- R12: The configuration register reads back the 6-bit value last written. Lock-register reads show {free-run, enable, lock} in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| devRst | input | 1 | Synchronous device reset (does not clear the sticky flag) |
| cfgWrEn | input | 1 | Control-register write strobe |
| cfgSel | input | 1 | 0 selects configuration, 1 selects lock |
| cfgWrData | input | 6 | Control-register write data |
| cfgRdData | output | 6 | Read data of the selected control register |
| memWrEn | input | 1 | Window write strobe |
| memAddr | input | 4 | Window byte offset, shared by reads and writes |
| memSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| memWrData | input | 32 | Window write data |
| memRdData | output | 32 | Window read data |
| irqPulse | output | 1 | Normal interrupt pulse at the end of phase one |
| smiPulse | output | 1 | Management interrupt pulse at the end of phase one |
| rebootPulse | output | 1 | Reboot request at the end of phase two |

## Verification
The countdown is run with small preloads on the fast scale and with one preload on the slow scale. The slow run separates the two shifts. A preload written with junk in its upper bits shows the 20-bit mask. Runs use each interrupt selection (normal, management, none) and both reboot settings, with and without free-run. This tells a reboot with state reset apart from a silent restart of phase one and from a stop. Keep-alives and preload writes are sent both through a correctly opened window and without one. A preload change in mid-count shows that it only affects the next load, and the exact pulse cycles show that a reload was taken.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef enum logic [1:0] {
    UNL_IDLE = 2'd0,
    UNL_HALF = 2'd1,
    UNL_OPEN = 2'd2
  } unlock_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAll;    // return preloads and counter to reset state
    logic ldStage1;  // load phase-one timeout and run
    logic ldStage2;  // load phase-two timeout and run
    logic stop;      // halt counting
    logic setPre1;   // capture phase-one preload
    logic setPre2;   // capture phase-two preload
  } wdogStb_t;

endpackage

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
#(
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdogStb_t         stb,
  input  logic             fastScale,
  input  logic [PRE_W-1:0] preData,
  output logic             expire,
  output logic             stageTwo
);

  localparam int CNT_W  = PRE_W + SLOW_SH;
  localparam int NSTAGE = 2;

  logic [PRE_W-1:0] preReg [NSTAGE];
  logic [NSTAGE-1:0] preWr;
  logic [CNT_W-1:0]  cnt;
  logic              running;

  assign preWr = {stb.setPre2, stb.setPre1};

  function automatic logic [CNT_W-1:0] scaleTmo(input logic [PRE_W-1:0] p,
                                                input logic fast);
    return fast ? (CNT_W'(p) << FAST_SH) : (CNT_W'(p) << SLOW_SH);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSTAGE; i++) preReg[i] <= '1;
    end else begin
      for (int i = 0; i < NSTAGE; i++) begin
        if (stb.clrAll)    preReg[i] <= '1;
        else if (preWr[i]) preReg[i] <= preData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      running  <= 1'b0;
      stageTwo <= 1'b0;
    end else if (stb.clrAll) begin
      cnt      <= '0;
      running  <= 1'b0;
      stageTwo <= 1'b0;
    end else if (stb.stop) begin
      running  <= 1'b0;
    end else if (stb.ldStage1) begin
      cnt      <= scaleTmo(preReg[0], fastScale);
      running  <= 1'b1;
      stageTwo <= 1'b0;
    end else if (stb.ldStage2) begin
      cnt      <= scaleTmo(preReg[1], fastScale);
      running  <= 1'b1;
      stageTwo <= 1'b1;
    end else if (running && cnt > CNT_W'(1)) begin
      cnt      <= cnt - CNT_W'(1);
    end
  end

  assign expire = running && (cnt <= CNT_W'(1));

  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && cnt > CNT_W'(1) && !stb.clrAll && !stb.stop && !stb.ldStage1 && !stb.ldStage2)
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R6
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stop && !stb.clrAll) |=> !expire);

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             devRst,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [5:0]       cfgWrData,
  output logic [5:0]       cfgRdData,
  input  logic             memWrEn,
  input  logic [3:0]       memAddr,
  input  logic [1:0]       memSize,
  input  logic [31:0]      memWrData,
  output logic [31:0]      memRdData,
  input  logic             expire,
  input  logic             stageTwo,
  output wdogStb_t         stb,
  output logic             fastScale,
  output logic [PRE_W-1:0] preData,
  output logic             irqPulse,
  output logic             smiPulse,
  output logic             rebootPulse
);

  localparam logic [3:0]  OFS_PRE1  = 4'h0;
  localparam logic [3:0]  OFS_PRE2  = 4'h4;
  localparam logic [3:0]  OFS_CTL   = 4'hC;
  localparam logic [31:0] MAGIC_A   = 32'h80;
  localparam logic [31:0] MAGIC_B   = 32'h86;
  localparam logic [31:0] FLAG_VIEW = 32'h1200;

  logic [5:0] cfgReg;
  logic       lockBit, enBit, freeRun, prevFlag;
  unlock_e    unl;

  logic        rebootDis;
  logic [1:0]  intSel;
  logic [31:0] wrVal;
  logic        isMagA, isMagB, actWr, keepAlive, clrFlag, wrP1, wrP2;
  logic        lockWr, enRise, enFall, bootHit;

  assign rebootDis = cfgReg[5];
  assign fastScale = cfgReg[2];
  assign intSel    = cfgReg[1:0];
  assign preData   = memWrData[PRE_W-1:0];

  always_comb begin
    case (memSize)
      SZ_BYTE: wrVal = {24'd0, memWrData[7:0]};
      SZ_HALF: wrVal = {16'd0, memWrData[15:0]};
      default: wrVal = memWrData;
    endcase
  end

  assign isMagA    = memWrEn && memAddr == OFS_CTL && wrVal == MAGIC_A;
  assign isMagB    = memWrEn && memAddr == OFS_CTL && wrVal == MAGIC_B && unl == UNL_HALF;
  assign actWr     = memWrEn && !isMagA && !isMagB && unl == UNL_OPEN &&
                     (memSize == SZ_HALF || memSize == SZ_WORD);
  assign keepAlive = actWr && memSize == SZ_HALF && memAddr == OFS_CTL && wrVal[8];
  assign clrFlag   = actWr && memSize == SZ_HALF && memAddr == OFS_CTL &&
                     (wrVal[9] || wrVal[12]);
  assign wrP1      = actWr && memSize == SZ_WORD && memAddr == OFS_PRE1;
  assign wrP2      = actWr && memSize == SZ_WORD && memAddr == OFS_PRE2;

  assign lockWr  = cfgWrEn && cfgSel && !lockBit;
  assign enRise  = lockWr && cfgWrData[1] && !enBit;
  assign enFall  = lockWr && !cfgWrData[1];
  assign bootHit = expire && stageTwo && !rebootDis;

  always_comb begin
    stb         = '0;
    stb.setPre1 = wrP1;
    stb.setPre2 = wrP2;
    if (devRst || bootHit) begin
      stb.clrAll = 1'b1;
    end else if (expire) begin
      if (!stageTwo)              stb.ldStage2 = 1'b1;
      else if (freeRun && enBit)  stb.ldStage1 = 1'b1;
      else                        stb.stop     = 1'b1;
    end else if (enFall) begin
      stb.stop = 1'b1;
    end else if (enRise || (keepAlive && enBit)) begin
      stb.ldStage1 = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg      <= '0;
      lockBit     <= 1'b0;
      enBit       <= 1'b0;
      freeRun     <= 1'b0;
      unl         <= UNL_IDLE;
      prevFlag    <= 1'b0;
      irqPulse    <= 1'b0;
      smiPulse    <= 1'b0;
      rebootPulse <= 1'b0;
    end else if (devRst || bootHit) begin
      cfgReg      <= '0;
      lockBit     <= 1'b0;
      enBit       <= 1'b0;
      freeRun     <= 1'b0;
      unl         <= UNL_IDLE;
      prevFlag    <= prevFlag || bootHit;
      irqPulse    <= 1'b0;
      smiPulse    <= 1'b0;
      rebootPulse <= bootHit && !devRst;
    end else begin
      if (cfgWrEn && !cfgSel) cfgReg <= cfgWrData;
      if (lockWr) begin
        lockBit <= cfgWrData[0];
        enBit   <= cfgWrData[1];
        freeRun <= cfgWrData[2];
      end
      if (isMagA)                               unl <= UNL_HALF;
      else if (isMagB)                          unl <= UNL_OPEN;
      else if (memWrEn && unl == UNL_OPEN && memSize != SZ_BYTE) unl <= UNL_IDLE;
      if (clrFlag) prevFlag <= 1'b0;
      irqPulse    <= expire && !stageTwo && intSel == 2'd0;
      smiPulse    <= expire && !stageTwo && intSel == 2'd2;
      rebootPulse <= 1'b0;
    end
  end

  assign cfgRdData = cfgSel ? {3'b000, freeRun, enBit, lockBit} : cfgReg;
  assign memRdData = (memSize == SZ_HALF && memAddr == OFS_CTL && prevFlag) ? FLAG_VIEW : '0;

  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqPulse, smiPulse, rebootPulse}));

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse || smiPulse) |=> !(irqPulse || smiPulse));

  // R4
  boot_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rebootPulse |-> prevFlag);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockBit && cfgWrEn && cfgSel && !devRst && !bootHit)
      |=> (lockBit && enBit == $past(enBit) && freeRun == $past(freeRun)));

  // R10
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (devRst && !bootHit) |=> (prevFlag == $past(prevFlag)));

endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
  import wdog_pkg::*;
#(
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        devRst,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic [5:0]  cfgWrData,
  output logic [5:0]  cfgRdData,
  input  logic        memWrEn,
  input  logic [3:0]  memAddr,
  input  logic [1:0]  memSize,
  input  logic [31:0] memWrData,
  output logic [31:0] memRdData,
  output logic        irqPulse,
  output logic        smiPulse,
  output logic        rebootPulse
);

  wdogStb_t         stb;
  logic             fastScale, expire, stageTwo;
  logic [PRE_W-1:0] preData;

  wdog_ctrl #(.PRE_W(PRE_W)) uCtrl (
    .clk, .rstN, .devRst,
    .cfgWrEn, .cfgSel, .cfgWrData, .cfgRdData,
    .memWrEn, .memAddr, .memSize, .memWrData, .memRdData,
    .expire, .stageTwo, .stb, .fastScale, .preData,
    .irqPulse, .smiPulse, .rebootPulse
  );

  wdog_dpath #(.PRE_W(PRE_W), .SLOW_SH(SLOW_SH), .FAST_SH(FAST_SH)) uDpath (
    .clk, .rstN, .stb, .fastScale, .preData, .expire, .stageTwo
  );

endmodule

// File: tb/tb_dual_stage_wdog.sv
`timescale 1ns/1ps
module tb_dual_stage_wdog;

  localparam int K_IRQ = 1, K_SMI = 2, K_BOOT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        devRst = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [5:0]  cfgWrData = '0;
  logic [5:0]  cfgRdData;
  logic        memWrEn = 1'b0;
  logic [3:0]  memAddr = '0;
  logic [1:0]  memSize = 2'd1;
  logic [31:0] memWrData = '0;
  logic [31:0] memRdData;
  logic        irqPulse, smiPulse, rebootPulse;

  typedef struct { int kind; int cyc; string tag; } evt_t;
  evt_t sbq[$];

  int  nChk = 0, nErr = 0, cyc = 0, edgeE = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_stage_wdog dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgW(input bit sel, input logic [5:0] d);
    cfgSel = sel; cfgWrData = d; cfgWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0;
    edgeE = cyc;
  endtask

  task automatic memW(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    memAddr = a; memSize = sz; memWrData = d; memWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    memWrEn = 1'b0; memSize = 2'd1;
    edgeE = cyc;
  endtask

  task automatic unlW(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    memW(4'hC, 2'd1, 32'h80);
    memW(4'hC, 2'd1, 32'h86);
    memW(a, sz, d);
  endtask

  task automatic expectEvt(input int k, input int c, input string tag);
    evt_t e;
    e.kind = k; e.cyc = c; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic readCfg(input bit sel, input logic [5:0] exp, input string tag);
    cfgSel = sel; #0.1;
    chk(cfgRdData == exp, tag, cfgRdData, exp);
  endtask

  task automatic readFlag(input logic [31:0] exp, input string tag);
    memAddr = 4'hC; memSize = 2'd1; #0.1;
    chk(memRdData == exp, tag, memRdData, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    chk(sbq.size() == 0, tag, sbq.size(), 0);
    sbq.delete();
  endtask

  // Monitor: every pulse must match the next expected event and its cycle
  always @(negedge clk) begin
    if (rstN && !done && (irqPulse || smiPulse || rebootPulse)) begin
      int k;
      k = rebootPulse ? K_BOOT : (smiPulse ? K_SMI : K_IRQ);
      if (sbq.size() == 0) begin
        chk(1'b0, "R3/R5 unexpected pulse", k, 0);
      end else begin
        evt_t e;
        e = sbq.pop_front();
        chk(e.kind == k, {e.tag, " kind"}, k, e.kind);
        chk(e.cyc == cyc, {e.tag, " cycle"}, cyc, e.cyc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    chk(!irqPulse && !smiPulse && !rebootPulse, "R1 pulses", {irqPulse, smiPulse, rebootPulse}, 0);
    readCfg(1'b0, 6'h00, "R1 config");
    readCfg(1'b1, 6'h00, "R1 lock");
    readFlag(32'h0, "R1 flag");

    // Scenario A: R2 mask/fast, R3 irq, R4 reboot, R8 unlock
    unlW(4'h0, 2'd2, 32'hABC0_0002);
    unlW(4'h4, 2'd2, 32'h0000_0003);
    cfgW(1'b0, 6'h04);
    readCfg(1'b0, 6'h04, "R12 config readback");
    cfgW(1'b1, 6'h02);
    readCfg(1'b1, 6'h02, "R12 lock readback");
    expectEvt(K_IRQ, edgeE + 64, "R2 R3 irq at preload<<5");
    expectEvt(K_BOOT, edgeE + 64 + 96, "R4 reboot after phase two");
    idle(180);
    drained("R4 events seen");
    readCfg(1'b0, 6'h00, "R4 config cleared");
    readCfg(1'b1, 6'h00, "R4 lock cleared");
    readFlag(32'h1200, "R10 flag after reboot");

    // Scenario B: R5 free-run, R3 smi, R8 closed window, R11 mid-count preload
    unlW(4'h0, 2'd2, 32'h2);
    unlW(4'h4, 2'd2, 32'h3);
    memW(4'h0, 2'd2, 32'h1);          // R8 no unlock: ignored
    memW(4'h4, 2'd2, 32'h9);          // R8 no unlock: ignored
    cfgW(1'b0, 6'h26);
    cfgW(1'b1, 6'h06);
    begin
      int e0;
      e0 = edgeE;
      idle(10);
      unlW(4'h4, 2'd2, 32'h1);        // R11 new phase-two preload
      unlW(4'h0, 2'd2, 32'h5);        // R11 phase one keeps counting 64
      expectEvt(K_SMI, e0 + 64, "R8 R11 smi phase one unchanged");
      expectEvt(K_SMI, e0 + 64 + 32 + 160, "R5 R11 free-run restart");
      idle(e0 + 64 + 32 + 170 - cyc);
      cfgW(1'b1, 6'h00);              // R6 stop
      idle(400);
    end
    drained("R5 R6 events and stop");
    readFlag(32'h1200, "R10 flag kept without reboot");

    // Scenario C: R7 lock, reboot releases lock, device reset releases lock
    cfgW(1'b0, 6'h04);
    cfgW(1'b1, 6'h03);
    begin
      int e0;
      e0 = edgeE;
      cfgW(1'b1, 6'h00);              // ignored while locked
      readCfg(1'b1, 6'h03, "R7 lock write ignored");
      expectEvt(K_IRQ, e0 + 160, "R7 still running while locked");
      expectEvt(K_BOOT, e0 + 160 + 32, "R7 reboot while locked");
      idle(e0 + 200 - cyc);
    end
    drained("R7 events");
    cfgW(1'b1, 6'h01);
    cfgW(1'b1, 6'h06);
    readCfg(1'b1, 6'h01, "R7 lock-only write ignored");
    devRst = 1'b1; idle(1); devRst = 1'b0;
    readCfg(1'b1, 6'h00, "R7 device reset releases lock");
    readFlag(32'h1200, "R10 flag kept through device reset");
    memW(4'hC, 2'd1, 32'h0200);
    readFlag(32'h1200, "R8 R10 clear without unlock ignored");
    unlW(4'hC, 2'd1, 32'h0200);
    readFlag(32'h0, "R10 clear by bit 9");

    // Scenario D: R9 keep-alive, R3 no interrupt for type 3
    unlW(4'h0, 2'd2, 32'h4);
    unlW(4'h4, 2'd2, 32'h2);
    cfgW(1'b0, 6'h07);
    unlW(4'hC, 2'd1, 32'h0100);       // R9 while disabled: no start
    idle(300);
    drained("R9 keep-alive while disabled");
    cfgW(1'b1, 6'h02);
    idle(40);
    memW(4'hC, 2'd1, 32'h0100);       // R8 closed: ignored
    idle(20);
    unlW(4'hC, 2'd1, 32'h0100);
    expectEvt(K_BOOT, edgeE + 128 + 64, "R9 R3 restart, no phase-one pulse");
    idle(210);
    drained("R9 events");
    readFlag(32'h1200, "R4 flag set again");
    unlW(4'hC, 2'd1, 32'h1000);
    readFlag(32'h0, "R10 clear by bit 12");

    // Scenario E: R2 slow scale
    unlW(4'h0, 2'd2, 32'h1);
    cfgW(1'b0, 6'h00);
    cfgW(1'b1, 6'h02);
    expectEvt(K_IRQ, edgeE + 32768, "R2 slow scale preload<<15");
    idle(32800);
    cfgW(1'b1, 6'h00);
    idle(20);
    drained("R2 slow events");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule